// File: doc/BRIEF.md
# Trunk-Rate Digital Phase-Locked Loop

This block is an all-digital PLL for a primary-rate trunk timing unit. It runs entirely on the master clock (20 MHz nominal). A phase accumulator, the numerically controlled oscillator, produces a carry stream whose average rate is 16.384 MHz. The loop steers that stream into phase with a single reference input, which may run at 8 kHz, 1.544 MHz or 2.048 MHz. A downstream clock generator takes the accumulator value and its carry and derives the line clocks and frame pulses.

The faster references are first divided down to an 8 kHz comparison tick. The carry stream is divided down to the same rate. At each tick, the phase detector reads the feedback count as a signed phase error and saturates it. A narrow first-order lowpass turns the saturated error into a frequency offset, and that offset is added to the nominal increment. A mode input, or the reserved rate code, clears the offset so that the oscillator free-runs at exactly its nominal increment.

Top module: `trunk_dpll`

## Requirements
- R1: `rst_n` is an active-low synchronous reset. A clock edge that samples it low clears the accumulator, the carry, the feedback count, the reference prescaler and the offset. The first increment after release is the nominal word.
- R2: On every clock edge the accumulator advances by the nominal word plus the signed offset, modulo 2^32. The nominal word is 3518437209, which is round(16.384/20 * 2^32). `carry_o` is high, for one cycle, exactly in the cycle after an addition that wrapped.
- R3: With `freerun` = 1 (FREERUN mode), the offset is cleared at every edge that samples the input. Every following increment equals the nominal word. `freerun` = 0 selects NORMAL tracking.
- R4: Rate code `rate_sel` = 00 is reserved. It clears the offset in the same way as FREERUN, whatever `freerun` and `ref_in` do.
- R5: Rate codes 01, 10 and 11 select 8 kHz, 1.544 MHz and 2.048 MHz references. Rising reference edges are counted and divided by 1, 193 and 256 respectively, and the last edge of each group forms a comparison tick.
- R6: The feedback divider counts carries modulo 2048. At a tick, the count as it stands before that cycle's update, read as a signed 11-bit number, is the phase error. A positive error means the oscillator is ahead.
- R7: The phase error is saturated to the range -127..+127 before filtering.
- R8: On a tick in NORMAL mode, the offset becomes offset + ((-error * 2^19 - offset) >>> 10), using an arithmetic shift. Between ticks the offset holds.
- R9: `ref_in` passes through two synchronising flops. A rising edge first sampled at clock edge k updates the offset at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (20 MHz nominal) |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in | input | 1 | Primary reference, asynchronous |
| rate_sel | input | 2 | Reference rate code: 00 reserved, 01 8 kHz, 10 1.544 MHz, 11 2.048 MHz |
| freerun | input | 1 | 1 = free-run at nominal, 0 = track reference |
| phase_o | output | 32 | Oscillator phase accumulator |
| carry_o | output | 1 | Registered accumulator wrap |

## Verification
A comparison tick can fall in the same cycle as a carry that bumps the feedback count, and that count may also be wrapping from 2047 to 0. The detector must use the count from before that cycle's update. The bench drives the 2.048 MHz and 1.544 MHz references with periods of 10 and 13 clocks against an oscillator that produces 0.8192 carries per clock, so the tick slides across carries and across the wrap point over the run. A cycle-by-cycle scoreboard model compares every accumulator and carry value, so any off-by-one in the sampled count shows up in the next increment.

// File: rtl/tdpll_pkg.sv
package tdpll_pkg;

    typedef enum logic [1:0] {
        RATE_RSVD = 2'b00,
        RATE_8K   = 2'b01,
        RATE_T1   = 2'b10,
        RATE_E1   = 2'b11
    } rate_e;

    typedef struct packed {
        logic  hold;
        rate_e rate;
    } loop_ctrl_t;

    localparam int unsigned T1_REF_DIV = 193;
    localparam int unsigned E1_REF_DIV = 256;

    // reference edges per 8 kHz comparison tick
    function automatic int unsigned ref_ratio(rate_e r);
        case (r)
            RATE_T1: return T1_REF_DIV;
            RATE_E1: return E1_REF_DIV;
            default: return 1;
        endcase
    endfunction

    // rounded accumulator increment for a target carry rate
    function automatic longint unsigned nominal_word(longint unsigned out_hz,
                                                     longint unsigned clk_hz,
                                                     int unsigned     acc_w);
        return ((out_hz << acc_w) + clk_hz / 2) / clk_hz;
    endfunction

endpackage

// File: rtl/tdpll_ref_front.sv
module tdpll_ref_front
    import tdpll_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PRE_W       = 9
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ref_in,
    input  rate_e rate,
    output logic  tick
);
    logic [SYNC_STAGES:0] sync_q;
    logic                 rise;
    logic [PRE_W-1:0]     pre_q;
    logic [PRE_W-1:0]     last;

    assign rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
    assign last = PRE_W'(ref_ratio(rate) - 1);
    assign tick = rise && (pre_q >= last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], ref_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (rise) begin
            pre_q <= (pre_q >= last) ? '0 : pre_q + 1'b1;
        end
    end

    // R9
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R5
    tick_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $rose(sync_q[SYNC_STAGES-1]));

endmodule

// File: rtl/tdpll_phase_det.sv
module tdpll_phase_det #(
    parameter int FB_W  = 11,
    parameter int ERR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    carry,
    input  logic                    tick,
    output logic signed [ERR_W-1:0] err
);
    localparam int ERR_MAX = (1 << (ERR_W - 1)) - 1;
    localparam logic signed [FB_W-1:0]  POS_LIM = FB_W'(ERR_MAX);
    localparam logic signed [FB_W-1:0]  NEG_LIM = FB_W'(-ERR_MAX);
    localparam logic signed [ERR_W-1:0] E_HI    = ERR_W'(ERR_MAX);
    localparam logic signed [ERR_W-1:0] E_LO    = ERR_W'(-ERR_MAX);

    logic [FB_W-1:0]        fb_q;
    logic signed [FB_W-1:0] raw;

    assign raw = $signed(fb_q);

    always_comb begin
        if (raw > POS_LIM)      err = E_HI;
        else if (raw < NEG_LIM) err = E_LO;
        else                    err = ERR_W'(raw);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fb_q <= '0;
        else        fb_q <= fb_q + FB_W'(carry);
    end

    // R7
    err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (err <= E_HI && err >= E_LO));

    // R6
    fb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carry |=> $stable(fb_q));

endmodule

// File: rtl/tdpll_loop_filter.sv
module tdpll_loop_filter
    import tdpll_pkg::*;
#(
    parameter int ERR_W    = 8,
    parameter int OFS_W    = 32,
    parameter int KP_SHIFT = 19,
    parameter int LP_SHIFT = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic signed [ERR_W-1:0] err,
    input  loop_ctrl_t              ctrl,
    output logic signed [OFS_W-1:0] ofs
);
    logic signed [OFS_W-1:0] ofs_q;
    logic signed [OFS_W-1:0] err_x;
    logic signed [OFS_W-1:0] target;
    logic signed [OFS_W-1:0] step;
    logic                    hold;

    assign hold   = ctrl.hold || (ctrl.rate == RATE_RSVD);
    assign err_x  = OFS_W'(err);
    assign target = -(err_x <<< KP_SHIFT);
    assign step   = (target - ofs_q) >>> LP_SHIFT;
    assign ofs    = ofs_q;

    always_ff @(posedge clk) begin
        if (!rst_n || hold) ofs_q <= '0;
        else if (tick)      ofs_q <= ofs_q + step;
    end

    // R3 R4
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (ofs == '0));

    // R8
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !hold) |=> $stable(ofs));

endmodule

// File: rtl/tdpll_dco.sv
module tdpll_dco #(
    parameter int               ACC_W = 32,
    parameter int               OFS_W = 32,
    parameter logic [ACC_W-1:0] NOM_W = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [OFS_W-1:0] ofs,
    output logic [ACC_W-1:0]        acc,
    output logic                    carry
);
    logic [ACC_W-1:0]        acc_q;
    logic                    carry_q;
    logic signed [ACC_W-1:0] ofs_x;
    logic [ACC_W-1:0]        inc;
    logic [ACC_W:0]          sum;

    assign ofs_x = ACC_W'(ofs);
    assign inc   = NOM_W + $unsigned(ofs_x);
    assign sum   = {1'b0, acc_q} + {1'b0, inc};
    assign acc   = acc_q;
    assign carry = carry_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            acc_q   <= sum[ACC_W-1:0];
            carry_q <= sum[ACC_W];
        end
    end

    // R2
    carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_q |-> (acc_q < $past(acc_q)));

endmodule

// File: rtl/trunk_dpll.sv
module trunk_dpll
    import tdpll_pkg::*;
#(
    parameter longint unsigned CLK_HZ   = 20000000,
    parameter longint unsigned DCO_HZ   = 16384000,
    parameter int              ACC_W    = 32,
    parameter int              FB_W     = 11,
    parameter int              ERR_W    = 8,
    parameter int              OFS_W    = 32,
    parameter int              PRE_W    = 9,
    parameter int              KP_SHIFT = 19,
    parameter int              LP_SHIFT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic [1:0]       rate_sel,
    input  logic             freerun,
    output logic [ACC_W-1:0] phase_o,
    output logic             carry_o
);
    localparam longint unsigned NOM   = nominal_word(DCO_HZ, CLK_HZ, ACC_W);
    localparam logic [ACC_W-1:0] NOM_W = ACC_W'(NOM);

    loop_ctrl_t              ctrl;
    logic                    tick;
    logic signed [ERR_W-1:0] err;
    logic signed [OFS_W-1:0] ofs;

    assign ctrl.hold = freerun;
    assign ctrl.rate = rate_e'(rate_sel);

    tdpll_ref_front #(.SYNC_STAGES(2), .PRE_W(PRE_W)) u_front (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .rate(ctrl.rate), .tick(tick)
    );

    tdpll_phase_det #(.FB_W(FB_W), .ERR_W(ERR_W)) u_pd (
        .clk(clk), .rst_n(rst_n), .carry(carry_o), .tick(tick), .err(err)
    );

    tdpll_loop_filter #(.ERR_W(ERR_W), .OFS_W(OFS_W), .KP_SHIFT(KP_SHIFT),
                        .LP_SHIFT(LP_SHIFT)) u_lf (
        .clk(clk), .rst_n(rst_n), .tick(tick), .err(err), .ctrl(ctrl), .ofs(ofs)
    );

    tdpll_dco #(.ACC_W(ACC_W), .OFS_W(OFS_W), .NOM_W(NOM_W)) u_dco (
        .clk(clk), .rst_n(rst_n), .ofs(ofs), .acc(phase_o), .carry(carry_o)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (phase_o == '0 && !carry_o));

endmodule

// File: tb/test_trunk_dpll.sv
module test_trunk_dpll;
    localparam longint NOM     = 64'd3518437209;
    localparam longint SAT_INC = NOM - 65024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_in = 1'b0;
    logic [1:0]  rate_sel = 2'b01;
    logic        freerun = 1'b1;
    logic [31:0] phase_o;
    logic        carry_o;

    trunk_dpll i_trunk_dpll (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .rate_sel(rate_sel),
        .freerun(freerun), .phase_o(phase_o), .carry_o(carry_o)
    );

    always #2 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // scoreboard reference model state (state after the latest clock edge)
    bit          m_s1, m_s2, m_s3, m_car;
    int          m_pre, m_fb;
    longint      m_f;
    bit [31:0]   m_acc;
    logic [32:0] exp_q[$];

    initial begin
        m_s1 = 0; m_s2 = 0; m_s3 = 0; m_car = 0;
        m_pre = 0; m_fb = 0; m_f = 0; m_acc = '0;
    end

    task automatic model_step();
        int        div;
        bit        rise, tick, hold, nc;
        int        e;
        bit [63:0] t;
        bit [32:0] s;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_car = 0;
            m_pre = 0; m_fb = 0; m_f = 0; m_acc = '0;
            return;
        end
        case (rate_sel)
            2'b10:   div = 193;
            2'b11:   div = 256;
            default: div = 1;
        endcase
        rise = m_s2 && !m_s3;
        tick = rise && (m_pre >= div - 1);
        e = (m_fb >= 1024) ? m_fb - 2048 : m_fb;
        if (e > 127)  e = 127;
        if (e < -127) e = -127;
        hold = freerun || (rate_sel == 2'b00);
        t = 64'(NOM) + 64'(m_f);
        s = {1'b0, m_acc} + {1'b0, t[31:0]};
        nc = s[32];
        m_acc = s[31:0];
        m_fb = (m_fb + int'(m_car)) % 2048;
        if (hold)      m_f = 0;
        else if (tick) m_f = m_f + (((-(longint'(e) <<< 19)) - m_f) >>> 10);
        if (rise) m_pre = (m_pre >= div - 1) ? 0 : m_pre + 1;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = ref_in;
        m_car = nc;
    endtask

    // monitor: pop expected, compare; driver side pushes the next expectation
    always @(negedge clk) begin
        logic [32:0] item;
        if (exp_q.size() > 0) begin
            item = exp_q.pop_front();
            n_chk++;
            if ({carry_o, phase_o} !== item) begin
                n_fail++;
                $display("FAIL %s: phase/carry got %h/%b expected %h/%b",
                         tag, phase_o, carry_o, item[31:0], item[32]);
            end
        end
        model_step();
        exp_q.push_back({m_car, m_acc});
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(string r, bit ok, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", r, act, expv);
        end
    endtask

    task automatic inc_check(string r, longint expv);
        bit [31:0] p0, p1, d;
        bit [31:0] e32;
        e32 = expv[31:0];
        @(negedge clk) p0 = phase_o;
        @(negedge clk) p1 = phase_o;
        d = p1 - p0;
        check(r, d == e32, longint'(d), longint'(e32));
        @(posedge clk);
        #1;
    endtask

    task automatic run_ref(int hi, int lo, int total);
        int k = 0;
        while (k < total) begin
            ref_in = 1'b1; cyc(hi);
            ref_in = 1'b0; cyc(lo);
            k += hi + lo;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset state and first increment
        cyc(5);
        @(negedge clk);
        check("R1", phase_o == 32'd0, longint'(phase_o), 0);
        check("R1", carry_o == 1'b0, longint'(carry_o), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        inc_check("R1", NOM);

        // R2: carry marks each wrap
        tag = "R2";
        begin
            bit [31:0] prev;
            @(negedge clk) prev = phase_o;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                check("R2", carry_o == (phase_o < prev), longint'(carry_o),
                      longint'(phase_o < prev));
                prev = phase_o;
            end
            @(posedge clk); #1;
        end

        // R3: free-run ignores a live reference
        tag = "R3";
        run_ref(1250, 1250, 5000);
        inc_check("R3", NOM);

        // R4: reserved rate code
        tag = "R4";
        freerun = 1'b0; rate_sel = 2'b00;
        run_ref(5, 5, 3000);
        inc_check("R4", NOM);

        // R7 / R9: first tick with a large feedback count saturates
        tag = "R1";
        rst_n = 1'b0; ref_in = 1'b0; rate_sel = 2'b01; freerun = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1000);
        tag = "R9";
        ref_in = 1'b1;
        cyc(8);
        inc_check("R7", SAT_INC);
        inc_check("R8", SAT_INC);

        // R6 R8: tracking an 8 kHz reference
        tag = "R6 R8";
        ref_in = 1'b0;
        cyc(1250);
        run_ref(1250, 1250, 20000);

        // R5: prescaled references, ticks sliding across carries
        tag = "R5 E1";
        rate_sel = 2'b11;
        run_ref(5, 5, 26000);
        tag = "R5 T1";
        rate_sel = 2'b10;
        run_ref(6, 7, 26000);

        // R3: switching to free-run clears the offset
        tag = "R3";
        freerun = 1'b1;
        cyc(2);
        inc_check("R3", NOM);

        cyc(3);
        finish_run();
    end
endmodule